// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Select with Split Register Files

This block decides, for the two ALU operands of an instruction in the execute stage, whether each operand is taken from the register file or bypassed from a younger result further down the pipeline. The pipeline has two separate register files: a general-purpose file and a floating-point file. A bypass is allowed only when the producer writes the same file the consumer reads, and an index matches. When both the memory stage and the write-back stage hold a usable result, the memory-stage result is chosen because it is newer.

A second output covers a load followed at once by a store. The load's result sits in write-back while the store is in the memory stage. The block then steers the write-back value onto the store-data path. The block is purely combinational and has no state. The surrounding datapath multiplexers, the stall logic and the register files lie outside it.

Top module: `ex_fwd_unit`

## Requirements
- R1: An operand select is 2'b10 (memory-stage result) when the memory stage writes the file that the operand reads and its destination index equals the operand index. For the general-purpose file, the index must also be nonzero.
- R2: An operand select is 2'b01 (write-back value) when the write-back stage matches the operand under the rules of R1 and the memory stage does not match.
- R3: When both the memory stage and the write-back stage match an operand, its select is 2'b10.
- R4: A producer that writes only the other register file never causes a bypass. The file-type flag is 0 for general-purpose and 1 for floating-point.
- R5: General-purpose index 0 is never bypassed. Floating-point index 0 is bypassed like any other index.
- R6: A stage whose two write enables are both low never causes a bypass, whatever its destination index.
- R7: Operands Rs and Rt are decided independently. A select is 2'b00 (register file) when neither stage matches, and 2'b11 never occurs.
- R8: The store-data select is 1 when all of the following hold: write-back writes the general-purpose file, the memory stage is a memory write, the write-back destination is nonzero, and that destination equals the store-data source index.
- R9: The store-data select is 0 whenever any condition of R8 fails. This includes write-back writing only the floating-point file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_idx_i | input | IDX_W | Execute-stage first operand index |
| rs_fpr_i | input | 1 | First operand reads floating-point file |
| rt_idx_i | input | IDX_W | Execute-stage second operand index |
| rt_fpr_i | input | 1 | Second operand reads floating-point file |
| mem_rd_i | input | IDX_W | Memory-stage destination index |
| mem_gpr_we_i | input | 1 | Memory stage writes general-purpose file |
| mem_fpr_we_i | input | 1 | Memory stage writes floating-point file |
| wb_rd_i | input | IDX_W | Write-back destination index |
| wb_gpr_we_i | input | 1 | Write-back writes general-purpose file |
| wb_fpr_we_i | input | 1 | Write-back writes floating-point file |
| mem_store_i | input | 1 | Memory-stage instruction is a memory write |
| mem_st_src_i | input | IDX_W | Register index supplying the store data |
| rs_sel_o | output | 2 | First operand select (00 file, 10 memory, 01 write-back) |
| rt_sel_o | output | 2 | Second operand select (same encoding) |
| st_sel_o | output | 1 | Store data taken from write-back value |

## Verification
A memory-stage hit and a write-back hit on the same operand can occur together, and so can a store-data bypass and an operand bypass. The directed tests place the same index in both destination slots, and in the store source and an operand, within one input pattern. Each output is then compared against a model written from the requirements. The memory-over-write-back priority is judged per operand. A sweep crosses every stage match kind with both operand file types, so that simultaneous hits with mismatched types are also covered.

// File: rtl/ex_fwd_pkg.sv
package ex_fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
  localparam int unsigned NUM_SRC = 2; // 0: mem, 1: wb (priority order)
endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] cons_idx_i,
  input  logic             cons_fpr_i,
  input  logic [IDX_W-1:0] prod_idx_i,
  input  logic             prod_gpr_we_i,
  input  logic             prod_fpr_we_i,
  output logic             hit_o
);
  logic idx_eq, idx_nz, gpr_hit, fpr_hit;

  always_comb begin
    idx_eq  = (prod_idx_i == cons_idx_i);
    idx_nz  = |prod_idx_i;
    // gpr index 0 is hardwired, fpr index 0 is a real register
    gpr_hit = prod_gpr_we_i & ~cons_fpr_i & idx_eq & idx_nz;
    fpr_hit = prod_fpr_we_i &  cons_fpr_i & idx_eq;
    hit_o   = gpr_hit | fpr_hit;
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import ex_fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0]         op_idx_i,
  input  logic                     op_fpr_i,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] src_rd_i,
  input  logic [NUM_SRC-1:0]       src_gpr_we_i,
  input  logic [NUM_SRC-1:0]       src_fpr_we_i,
  output fwd_sel_e                 sel_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    fwd_stage_match #(.IDX_W(IDX_W)) u_match (
      .cons_idx_i   (op_idx_i),
      .cons_fpr_i   (op_fpr_i),
      .prod_idx_i   (src_rd_i[s]),
      .prod_gpr_we_i(src_gpr_we_i[s]),
      .prod_fpr_we_i(src_fpr_we_i[s]),
      .hit_o        (hit[s])
    );
  end

  // newest stage wins
  always_comb begin
    if (hit[0])      sel_o = FWD_MEM;
    else if (hit[1]) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/fwd_store_bypass.sv
module fwd_store_bypass #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_gpr_we_i,
  input  logic             mem_store_i,
  input  logic [IDX_W-1:0] st_src_i,
  output logic             st_sel_o
);
  logic wb_hit;

  // store data always comes from the gpr file
  fwd_stage_match #(.IDX_W(IDX_W)) u_match (
    .cons_idx_i   (st_src_i),
    .cons_fpr_i   (1'b0),
    .prod_idx_i   (wb_rd_i),
    .prod_gpr_we_i(wb_gpr_we_i),
    .prod_fpr_we_i(1'b0),
    .hit_o        (wb_hit)
  );

  assign st_sel_o = wb_hit & mem_store_i;
endmodule

// File: rtl/ex_fwd_unit.sv
module ex_fwd_unit
  import ex_fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] rs_idx_i,
  input  logic             rs_fpr_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  input  logic             rt_fpr_i,
  input  logic [IDX_W-1:0] mem_rd_i,
  input  logic             mem_gpr_we_i,
  input  logic             mem_fpr_we_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_gpr_we_i,
  input  logic             wb_fpr_we_i,
  input  logic             mem_store_i,
  input  logic [IDX_W-1:0] mem_st_src_i,
  output logic [1:0]       rs_sel_o,
  output logic [1:0]       rt_sel_o,
  output logic             st_sel_o
);
  logic [NUM_OPS-1:0][IDX_W-1:0] op_idx;
  logic [NUM_OPS-1:0]            op_fpr;
  fwd_sel_e                      op_sel [NUM_OPS];
  logic [NUM_SRC-1:0][IDX_W-1:0] src_rd;
  logic [NUM_SRC-1:0]            src_gpr_we;
  logic [NUM_SRC-1:0]            src_fpr_we;

  assign op_idx     = {rt_idx_i, rs_idx_i};
  assign op_fpr     = {rt_fpr_i, rs_fpr_i};
  assign src_rd     = {wb_rd_i, mem_rd_i};
  assign src_gpr_we = {wb_gpr_we_i, mem_gpr_we_i};
  assign src_fpr_we = {wb_fpr_we_i, mem_fpr_we_i};

  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    fwd_operand_sel #(.IDX_W(IDX_W)) u_sel (
      .op_idx_i    (op_idx[o]),
      .op_fpr_i    (op_fpr[o]),
      .src_rd_i    (src_rd),
      .src_gpr_we_i(src_gpr_we),
      .src_fpr_we_i(src_fpr_we),
      .sel_o       (op_sel[o])
    );
  end

  assign rs_sel_o = op_sel[0];
  assign rt_sel_o = op_sel[1];

  fwd_store_bypass #(.IDX_W(IDX_W)) u_st (
    .wb_rd_i    (wb_rd_i),
    .wb_gpr_we_i(wb_gpr_we_i),
    .mem_store_i(mem_store_i),
    .st_src_i   (mem_st_src_i),
    .st_sel_o   (st_sel_o)
  );
endmodule

// File: rtl/ex_fwd_unit_chk.sv
module ex_fwd_unit_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic [IDX_W-1:0] rs_idx_i,
  input logic             rs_fpr_i,
  input logic [IDX_W-1:0] rt_idx_i,
  input logic             rt_fpr_i,
  input logic [IDX_W-1:0] mem_rd_i,
  input logic             mem_gpr_we_i,
  input logic             mem_fpr_we_i,
  input logic [IDX_W-1:0] wb_rd_i,
  input logic             wb_gpr_we_i,
  input logic             wb_fpr_we_i,
  input logic             mem_store_i,
  input logic [IDX_W-1:0] mem_st_src_i,
  input logic [1:0]       rs_sel_o,
  input logic [1:0]       rt_sel_o,
  input logic             st_sel_o
);
  logic rs_mem_ok, rs_wb_ok, rt_mem_ok;

  always_comb begin
    rs_mem_ok = (mem_rd_i == rs_idx_i) &&
                (rs_fpr_i ? mem_fpr_we_i : (mem_gpr_we_i && rs_idx_i != '0));
    rs_wb_ok  = (wb_rd_i == rs_idx_i) &&
                (rs_fpr_i ? wb_fpr_we_i : (wb_gpr_we_i && rs_idx_i != '0));
    rt_mem_ok = (mem_rd_i == rt_idx_i) &&
                (rt_fpr_i ? mem_fpr_we_i : (mem_gpr_we_i && rt_idx_i != '0));

    // R7
    sel_legal_chk: assert (rs_sel_o != 2'b11 && rt_sel_o != 2'b11)
      else $error("illegal select code");
    // R1
    rs_mem_src_chk: assert (rs_sel_o != 2'b10 || rs_mem_ok)
      else $error("rs mem bypass without match");
    // R1
    rt_mem_src_chk: assert (rt_sel_o != 2'b10 || rt_mem_ok)
      else $error("rt mem bypass without match");
    // R3
    rs_mem_prio_chk: assert (!rs_mem_ok || rs_sel_o == 2'b10)
      else $error("rs mem match not taken");
    // R2
    rs_wb_src_chk: assert (rs_sel_o != 2'b01 || (rs_wb_ok && !rs_mem_ok))
      else $error("rs wb bypass illegal");
    // R5
    rs_zero_chk: assert (rs_fpr_i || rs_idx_i != '0 || rs_sel_o == 2'b00)
      else $error("gpr zero bypassed");
    // R6
    mem_idle_chk: assert (mem_gpr_we_i || mem_fpr_we_i ||
                          (rs_sel_o != 2'b10 && rt_sel_o != 2'b10))
      else $error("idle mem stage bypassed");
    // R8
    st_cond_chk: assert (!st_sel_o || (wb_gpr_we_i && mem_store_i &&
                         wb_rd_i != '0 && wb_rd_i == mem_st_src_i))
      else $error("store bypass without conditions");
    // R8
    st_take_chk: assert (st_sel_o || !(wb_gpr_we_i && mem_store_i &&
                         wb_rd_i != '0 && wb_rd_i == mem_st_src_i))
      else $error("store bypass missed");
  end
endmodule

bind ex_fwd_unit ex_fwd_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .rs_idx_i    (rs_idx_i),
  .rs_fpr_i    (rs_fpr_i),
  .rt_idx_i    (rt_idx_i),
  .rt_fpr_i    (rt_fpr_i),
  .mem_rd_i    (mem_rd_i),
  .mem_gpr_we_i(mem_gpr_we_i),
  .mem_fpr_we_i(mem_fpr_we_i),
  .wb_rd_i     (wb_rd_i),
  .wb_gpr_we_i (wb_gpr_we_i),
  .wb_fpr_we_i (wb_fpr_we_i),
  .mem_store_i (mem_store_i),
  .mem_st_src_i(mem_st_src_i),
  .rs_sel_o    (rs_sel_o),
  .rt_sel_o    (rt_sel_o),
  .st_sel_o    (st_sel_o)
);

// File: tb/ex_fwd_unit_test.sv
module ex_fwd_unit_test;
  localparam int unsigned IDX_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [IDX_W-1:0] rs_idx, rt_idx, mem_rd, wb_rd, st_src;
  logic rs_fpr, rt_fpr, mem_gwe, mem_fwe, wb_gwe, wb_fwe, mem_st;
  logic [1:0] rs_sel, rt_sel;
  logic st_sel;

  int checks = 0;
  int failures = 0;

  ex_fwd_unit #(.IDX_W(IDX_W)) uut (
    .rs_idx_i(rs_idx), .rs_fpr_i(rs_fpr), .rt_idx_i(rt_idx), .rt_fpr_i(rt_fpr),
    .mem_rd_i(mem_rd), .mem_gpr_we_i(mem_gwe), .mem_fpr_we_i(mem_fwe),
    .wb_rd_i(wb_rd), .wb_gpr_we_i(wb_gwe), .wb_fpr_we_i(wb_fwe),
    .mem_store_i(mem_st), .mem_st_src_i(st_src),
    .rs_sel_o(rs_sel), .rt_sel_o(rt_sel), .st_sel_o(st_sel)
  );

  function automatic logic hit(logic [IDX_W-1:0] ci, logic cf,
                               logic [IDX_W-1:0] pi, logic gwe, logic fwe);
    if (pi != ci) return 1'b0;
    if (cf) return fwe;
    return gwe && (ci != '0);
  endfunction

  function automatic logic [1:0] model_sel(logic [IDX_W-1:0] ci, logic cf);
    if (hit(ci, cf, mem_rd, mem_gwe, mem_fwe)) return 2'b10;
    if (hit(ci, cf, wb_rd, wb_gwe, wb_fwe))    return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input logic [IDX_W-1:0] a_rs, input logic a_rsf,
                       input logic [IDX_W-1:0] a_rt, input logic a_rtf,
                       input logic [IDX_W-1:0] a_mrd, input logic a_mg, input logic a_mf,
                       input logic [IDX_W-1:0] a_wrd, input logic a_wg, input logic a_wf,
                       input logic a_st, input logic [IDX_W-1:0] a_src);
    @(posedge clk);
    rs_idx = a_rs; rs_fpr = a_rsf; rt_idx = a_rt; rt_fpr = a_rtf;
    mem_rd = a_mrd; mem_gwe = a_mg; mem_fwe = a_mf;
    wb_rd = a_wrd; wb_gwe = a_wg; wb_fwe = a_wf;
    mem_st = a_st; st_src = a_src;
    @(negedge clk);
  endtask

  task automatic chk2(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    logic e_st;
    e_st = wb_gwe && mem_st && (wb_rd != '0) && (wb_rd == st_src);
    chk2({tag, " rs"}, rs_sel, model_sel(rs_idx, rs_fpr));
    chk2({tag, " rt"}, rt_sel, model_sel(rt_idx, rt_fpr));
    chk2({tag, " st"}, {1'b0, st_sel}, {1'b0, e_st});
  endtask

  task automatic t_idle();
    drive(5'd3, 0, 5'd4, 0, 5'd0, 0, 0, 5'd0, 0, 0, 0, 5'd0);
    chk2("R7 idle rs", rs_sel, 2'b00);
    chk2("R7 idle rt", rt_sel, 2'b00);
    chk2("R9 idle st", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_mem_hit();
    drive(5'd7, 0, 5'd2, 0, 5'd7, 1, 0, 5'd0, 0, 0, 0, 5'd0);
    chk2("R1 mem gpr rs", rs_sel, 2'b10);
    chk2("R7 rt untouched", rt_sel, 2'b00);
    drive(5'd1, 1, 5'd9, 1, 5'd9, 0, 1, 5'd0, 0, 0, 0, 5'd0);
    chk2("R1 mem fpr rt", rt_sel, 2'b10);
    chk2("R7 rs untouched", rs_sel, 2'b00);
  endtask

  task automatic t_wb_hit();
    drive(5'd12, 0, 5'd12, 1, 5'd5, 1, 0, 5'd12, 1, 0, 0, 5'd0);
    chk2("R2 wb gpr rs", rs_sel, 2'b01);
    chk2("R4 wb gpr vs fpr rt", rt_sel, 2'b00);
    drive(5'd20, 1, 5'd6, 0, 5'd20, 1, 0, 5'd20, 0, 1, 0, 5'd0);
    chk2("R2 wb fpr rs behind gpr mem", rs_sel, 2'b01);
  endtask

  task automatic t_both();
    drive(5'd8, 0, 5'd8, 0, 5'd8, 1, 0, 5'd8, 1, 0, 0, 5'd0);
    chk2("R3 both rs", rs_sel, 2'b10);
    chk2("R3 both rt", rt_sel, 2'b10);
    drive(5'd8, 1, 5'd8, 0, 5'd8, 0, 1, 5'd8, 1, 0, 0, 5'd0);
    chk2("R7 indep rs mem", rs_sel, 2'b10);
    chk2("R7 indep rt wb", rt_sel, 2'b01);
  endtask

  task automatic t_mismatch();
    drive(5'd4, 1, 5'd4, 0, 5'd4, 1, 0, 5'd4, 0, 1, 0, 5'd0);
    chk2("R4 rs fpr sees wb", rs_sel, 2'b01);
    chk2("R4 rt gpr sees mem", rt_sel, 2'b10);
    drive(5'd4, 1, 5'd4, 0, 5'd4, 1, 0, 5'd4, 1, 0, 0, 5'd0);
    chk2("R4 rs fpr blocked", rs_sel, 2'b00);
  endtask

  task automatic t_zero();
    drive(5'd0, 0, 5'd0, 1, 5'd0, 1, 1, 5'd0, 1, 1, 0, 5'd0);
    chk2("R5 gpr0 rs", rs_sel, 2'b00);
    chk2("R5 fpr0 rt", rt_sel, 2'b10);
    drive(5'd0, 0, 5'd0, 1, 5'd0, 1, 0, 5'd0, 0, 1, 0, 5'd0);
    chk2("R5 fpr0 rt wb", rt_sel, 2'b01);
  endtask

  task automatic t_no_we();
    drive(5'd10, 0, 5'd10, 1, 5'd10, 0, 0, 5'd10, 0, 0, 1, 5'd10);
    chk2("R6 rs", rs_sel, 2'b00);
    chk2("R6 rt", rt_sel, 2'b00);
    chk2("R9 no wb write st", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_store();
    drive(5'd6, 0, 5'd3, 0, 5'd6, 1, 0, 5'd6, 1, 0, 1, 5'd6);
    chk2("R8 st", {1'b0, st_sel}, 2'b01);
    chk2("R3 with st rs", rs_sel, 2'b10);
    drive(5'd6, 0, 5'd3, 0, 5'd1, 0, 0, 5'd3, 1, 0, 1, 5'd3);
    chk2("R8 st with rt", {1'b0, st_sel}, 2'b01);
    chk2("R2 with st rt", rt_sel, 2'b01);
  endtask

  task automatic t_store_block();
    drive(5'd1, 0, 5'd1, 0, 5'd0, 0, 0, 5'd6, 1, 0, 0, 5'd6);
    chk2("R9 no mem write", {1'b0, st_sel}, 2'b00);
    drive(5'd1, 0, 5'd1, 0, 5'd0, 0, 0, 5'd6, 0, 1, 1, 5'd6);
    chk2("R9 wb fpr only", {1'b0, st_sel}, 2'b00);
    drive(5'd1, 0, 5'd1, 0, 5'd0, 0, 0, 5'd0, 1, 0, 1, 5'd0);
    chk2("R9 wb rd zero", {1'b0, st_sel}, 2'b00);
    drive(5'd1, 0, 5'd1, 0, 5'd0, 0, 0, 5'd6, 1, 0, 1, 5'd7);
    chk2("R9 index differs", {1'b0, st_sel}, 2'b00);
  endtask

  // kind: 0 none, 1 gpr same idx, 2 fpr same idx, 3 both enables other idx
  task automatic t_sweep();
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
        for (int f = 0; f < 4; f++) begin
          logic [IDX_W-1:0] i0;
          i0 = (f[1]) ? 5'd0 : 5'd13;
          drive(i0, f[0], i0, ~f[0],
                (m == 3) ? 5'd14 : i0, (m == 1 || m == 3), (m == 2 || m == 3),
                (w == 3) ? 5'd14 : i0, (w == 1 || w == 3), (w == 2 || w == 3),
                f[0], i0);
          chk_all("R1 R2 R3 R4 R5 R8 sweep");
        end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rs_idx = '0; rt_idx = '0; mem_rd = '0; wb_rd = '0; st_src = '0;
    rs_fpr = 0; rt_fpr = 0; mem_gwe = 0; mem_fwe = 0; wb_gwe = 0; wb_fwe = 0;
    mem_st = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_mem_hit();
    t_wb_hit();
    t_both();
    t_mismatch();
    t_zero();
    t_no_we();
    t_store();
    t_store_block();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule